// File: doc/BRIEF.md
# Target Transaction Retry and Disconnect Controller

This block is the target-side handshake unit that sits between a multiplexed host bus and a byte-wide local bus cycle generator. When an address phase arrives with the decode hit asserted, it claims the transaction. It waits for the initiator to signal ready on the single data phase and turns that phase into exactly one byte request to the local engine. It then ends the host transaction in one of three ways: normal completion, disconnect with data, or retry.

Every transaction must end within a fixed number of clocks of its address phase, 16 by default. A write is always carried out. For a read, the block does not start the local cycle and then find out too late. In the cycle where initiator-ready is first seen, it adds the local timing offset and the programmed setup, strobe and hold lengths to the current cycle number. If that predicted finish lies past the limit, it posts a retry at once and leaves the local bus untouched. Bursts are never followed past the first data phase. Back-to-back transactions are taken without an enforced idle cycle.

Top module: `tgt_retry_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `devsel_o`, `trdy_o`, `stop_o` and `lreq_o` are all low.
- R2: An address phase (`frame_i` high while the block is idle) with `hit_i` high raises `devsel_o` in the next cycle. `devsel_o` stays high until the termination or drain cycles end. An address phase with `hit_i` low produces no `devsel_o`, `trdy_o`, `stop_o` or `lreq_o` for the whole foreign transaction, which ends when `frame_i` and `irdy_i` are both low.
- R3: Number the address-phase cycle 1. If a read first sees `irdy_i` in cycle c and c + 2 + setup + strobe + hold > 16, the next cycle is a termination cycle with `stop_o`=1 and `trdy_o`=0, and no local request is issued.
- R4: A read that is not retried pulses `lreq_o` in the cycle after `irdy_i` is seen, with `lwrite_o`=0. In the cycle after `ldone_i`, `trdy_o`=1 and `rdata_o` equals the `lrdata_i` value presented with `ldone_i`. A read whose prediction equals 16 exactly is not retried.
- R5: A write is never retried, whatever its timing. It pulses `lreq_o` in the cycle after `irdy_i` is seen, with `lwrite_o`=1 and `lwdata_o` equal to `wdata_i` sampled with `irdy_i`. `trdy_o` rises in the cycle after `ldone_i`.
- R6: If `frame_i` is still high in the cycle where `irdy_i` is first seen (a burst), the termination cycle asserts `stop_o` together with `trdy_o`, which is a disconnect with data. Otherwise a completed transfer has `stop_o`=0.
- R7: If `frame_i` is high during the termination cycle, `stop_o` and `devsel_o` stay high and `trdy_o` stays low until `frame_i` is seen low. The block goes idle in the cycle after that.
- R8: An address phase in the cycle right after a termination or drain cycle is claimed like any other. No idle cycle is forced in between.
- R9: At most one `lreq_o` pulse, lasting one cycle, is issued per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Transaction framing, active high |
| irdy_i | input | 1 | Initiator ready, active high |
| hit_i | input | 1 | Address decode hit, valid in the address phase |
| cmd_wr_i | input | 1 | 1 = write command, valid in the address phase |
| wdata_i | input | 8 | Write byte, valid with irdy_i |
| setup_i | input | 4 | Local address/select setup length in clocks |
| strobe_i | input | 4 | Local strobe length in clocks |
| hold_i | input | 4 | Local hold length in clocks |
| lreq_o | output | 1 | One-cycle request to the local bus engine |
| lwrite_o | output | 1 | Direction of the local request, 1 = write |
| lwdata_o | output | 8 | Byte to write on the local bus |
| ldone_i | input | 1 | Local cycle finished pulse |
| lrdata_i | input | 8 | Byte read from the local bus, valid with ldone_i |
| devsel_o | output | 1 | Device select (claim) |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Stop (retry or disconnect) |
| rdata_o | output | 8 | Read byte returned to the host |

## Verification
Data completion and burst cut-off fall in the same termination cycle. The stimulus holds `frame_i` high at the moment `irdy_i` is raised, and the bench then expects `trdy_o` and `stop_o` together, followed by drain cycles of chosen length. The same coincidence is provoked on reads whose predicted finish sits on or just past the 16-clock limit. There the bench's own arithmetic decides between retry (stop without target-ready) and disconnect with data, and the observed handshakes must match that choice. Random transactions are launched with no idle gap so that a termination and the next address phase meet.

// File: rtl/tgt_retry_pkg.sv
package tgt_retry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_IGNORE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_ACCESS = 3'd3,
    ST_TERM   = 3'd4,
    ST_DRAIN  = 3'd5
  } tgt_state_e;

  // Predicted clock number (address phase = 1) at which the local cycle ends.
  function automatic logic [31:0] finish_cycle(input logic [31:0] now,
                                               input logic [31:0] ref_off,
                                               input logic [31:0] setup,
                                               input logic [31:0] strobe,
                                               input logic [31:0] hold);
    return now + ref_off + setup + strobe + hold;
  endfunction

endpackage

// File: rtl/tgt_elapsed_cnt.sv
module tgt_elapsed_cnt #(
  parameter int CNT_W = 6,
  parameter int FIRST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= CNT_FIRST;
    end else if (run_i && (cnt_o != CNT_MAX)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tgt_retry_judge.sv
module tgt_retry_judge #(
  parameter int CNT_W   = 6,
  parameter int TW      = 4,
  parameter int LIMIT   = 16,
  parameter int REF_OFF = 2
) (
  input  logic [CNT_W-1:0] now_i,
  input  logic [TW-1:0]    setup_i,
  input  logic [TW-1:0]    strobe_i,
  input  logic [TW-1:0]    hold_i,
  output logic             over_o
);
  logic [31:0] finish;

  always_comb begin
    finish = tgt_retry_pkg::finish_cycle(32'(now_i), 32'(REF_OFF),
                                         32'(setup_i), 32'(strobe_i),
                                         32'(hold_i));
    over_o = finish > 32'(LIMIT);
  end
endmodule

// File: rtl/tgt_hshake_out.sv
module tgt_hshake_out
  import tgt_retry_pkg::*;
(
  input  tgt_state_e st_i,
  input  logic       ok_i,
  input  logic       burst_i,
  output logic       devsel_o,
  output logic       trdy_o,
  output logic       stop_o
);
  always_comb begin
    devsel_o = (st_i == ST_WAIT) || (st_i == ST_ACCESS) ||
               (st_i == ST_TERM) || (st_i == ST_DRAIN);
    trdy_o   = (st_i == ST_TERM) && ok_i;
    stop_o   = ((st_i == ST_TERM) && (!ok_i || burst_i)) || (st_i == ST_DRAIN);
  end
endmodule

// File: rtl/tgt_retry_ctrl.sv
module tgt_retry_ctrl
  import tgt_retry_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TW      = 4,
  parameter int LIMIT   = 16,
  parameter int REF_OFF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  input  logic          irdy_i,
  input  logic          hit_i,
  input  logic          cmd_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] strobe_i,
  input  logic [TW-1:0] hold_i,
  output logic          lreq_o,
  output logic          lwrite_o,
  output logic [DW-1:0] lwdata_o,
  input  logic          ldone_i,
  input  logic [DW-1:0] lrdata_i,
  output logic          devsel_o,
  output logic          trdy_o,
  output logic          stop_o,
  output logic [DW-1:0] rdata_o
);
  // Counter wide enough to hold the limit plus the largest timing sum.
  localparam int SUM_MAX = LIMIT + REF_OFF + 3 * ((1 << TW) - 1);
  localparam int CNT_W   = $clog2(SUM_MAX + 2);

  tgt_state_e st_q, st_d;
  logic [CNT_W-1:0] now;
  logic over_limit;
  logic wr_q, burst_q, ok_q, lreq_q;
  logic [DW-1:0] lwdata_q, rdata_q;

  // Named events for the checker.
  logic addr_ev, claim_ev, dec_ev, retry_ev, accept_ev, done_ev;

  assign addr_ev   = (st_q == ST_IDLE) && frame_i;
  assign claim_ev  = addr_ev && hit_i;
  assign dec_ev    = (st_q == ST_WAIT) && irdy_i;
  assign retry_ev  = dec_ev && !wr_q && over_limit;
  assign accept_ev = dec_ev && !retry_ev;
  assign done_ev   = (st_q == ST_ACCESS) && ldone_i;

  tgt_elapsed_cnt #(.CNT_W(CNT_W), .FIRST(2)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (claim_ev),
    .run_i  (st_q == ST_WAIT),
    .cnt_o  (now)
  );

  tgt_retry_judge #(.CNT_W(CNT_W), .TW(TW), .LIMIT(LIMIT), .REF_OFF(REF_OFF)) u_judge (
    .now_i    (now),
    .setup_i  (setup_i),
    .strobe_i (strobe_i),
    .hold_i   (hold_i),
    .over_o   (over_limit)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (frame_i) st_d = hit_i ? ST_WAIT : ST_IGNORE;
      ST_IGNORE: if (!frame_i && !irdy_i) st_d = ST_IDLE;
      ST_WAIT:   if (dec_ev) st_d = retry_ev ? ST_TERM : ST_ACCESS;
      ST_ACCESS: if (ldone_i) st_d = ST_TERM;
      ST_TERM:   st_d = frame_i ? ST_DRAIN : ST_IDLE;
      ST_DRAIN:  if (!frame_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wr_q     <= 1'b0;
      burst_q  <= 1'b0;
      ok_q     <= 1'b0;
      lreq_q   <= 1'b0;
      lwdata_q <= '0;
      rdata_q  <= '0;
    end else begin
      st_q   <= st_d;
      lreq_q <= accept_ev;
      if (claim_ev) wr_q <= cmd_wr_i;
      if (dec_ev) begin
        burst_q <= frame_i;
        ok_q    <= !retry_ev;
        if (wr_q) lwdata_q <= wdata_i;
      end
      if (done_ev && !wr_q) rdata_q <= lrdata_i;
    end
  end

  tgt_hshake_out u_out (
    .st_i     (st_q),
    .ok_i     (ok_q),
    .burst_i  (burst_q),
    .devsel_o (devsel_o),
    .trdy_o   (trdy_o),
    .stop_o   (stop_o)
  );

  assign lreq_o   = lreq_q;
  assign lwrite_o = wr_q;
  assign lwdata_o = lwdata_q;
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/tgt_retry_ctrl_chk.sv
module tgt_retry_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_i,
  input logic hit_i,
  input logic ldone_i,
  input logic lreq_o,
  input logic devsel_o,
  input logic trdy_o,
  input logic stop_o,
  input logic retry_ev,
  input logic accept_ev,
  input logic wr_q
);
  AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_o |-> devsel_o); // R2
  AST_DEVSEL_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_o) |-> $past(frame_i && hit_i)); // R2
  AST_RETRY_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ev |=> (stop_o && !trdy_o && !lreq_o)); // R3
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> lreq_o); // R4
  AST_TRDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_o |-> $past(ldone_i)); // R4
  AST_WRITE_NEVER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ev |-> !wr_q); // R5
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && frame_i) |=> (stop_o && !trdy_o)); // R7
  AST_LREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_o |=> !lreq_o); // R9
endmodule

bind tgt_retry_ctrl tgt_retry_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_i   (frame_i),
  .hit_i     (hit_i),
  .ldone_i   (ldone_i),
  .lreq_o    (lreq_o),
  .devsel_o  (devsel_o),
  .trdy_o    (trdy_o),
  .stop_o    (stop_o),
  .retry_ev  (retry_ev),
  .accept_ev (accept_ev),
  .wr_q      (wr_q)
);

// File: tb/tb_tgt_retry_ctrl.sv
module tb_tgt_retry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_i = 1'b0, irdy_i = 1'b0, hit_i = 1'b0, cmd_wr_i = 1'b0;
  logic [7:0] wdata_i = '0, lrdata_i = '0;
  logic [3:0] setup_i = '0, strobe_i = '0, hold_i = '0;
  logic ldone_i = 1'b0;
  logic lreq_o, lwrite_o, devsel_o, trdy_o, stop_o;
  logic [7:0] lwdata_o, rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit prev_term = 1'b0;

  always #4 clk = ~clk;

  tgt_retry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i), .hit_i(hit_i),
    .cmd_wr_i(cmd_wr_i), .wdata_i(wdata_i), .setup_i(setup_i), .strobe_i(strobe_i),
    .hold_i(hold_i), .lreq_o(lreq_o), .lwrite_o(lwrite_o), .lwdata_o(lwdata_o),
    .ldone_i(ldone_i), .lrdata_i(lrdata_i), .devsel_o(devsel_o), .trdy_o(trdy_o),
    .stop_o(stop_o), .rdata_o(rdata_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit predict_retry(input bit wr, input int c, input int s, input int st, input int h);
    int limit_ok;
    limit_ok = (c + 2 + s + st + h) <= 16 ? 1 : 0;
    return !wr && (limit_ok == 0);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_quiet(input string req);
    check(req, "devsel", int'(devsel_o), 0);
    check(req, "trdy", int'(trdy_o), 0);
    check(req, "stop", int'(stop_o), 0);
    check(req, "lreq", int'(lreq_o), 0);
  endtask

  // Starts and ends at a negedge; leaves the block in an idle cycle.
  task automatic run_txn(input bit wr, input bit hit, input bit burst, input int dly,
                         input int s, input int st, input int h, input int drain,
                         input int gap);
    bit rty;
    int lat;
    logic [7:0] wd, rd;
    setup_i = 4'(s); strobe_i = 4'(st); hold_i = 4'(h);
    frame_i = 1'b1; hit_i = hit; cmd_wr_i = wr; irdy_i = 1'b0;
    tick();
    hit_i = 1'b0;
    if (!hit) begin
      check_quiet("R2");
      for (int i = 0; i < dly; i++) begin tick(); check_quiet("R2"); end
      irdy_i = 1'b1; frame_i = burst;
      tick(); check_quiet("R2");
      if (burst) begin frame_i = 1'b0; tick(); check_quiet("R2"); end
      irdy_i = 1'b0;
      tick(); check_quiet("R2");
      prev_term = 1'b0;
      for (int i = 0; i < gap; i++) tick();
      return;
    end
    check(prev_term ? "R8" : "R2", "devsel after claim", int'(devsel_o), 1);
    for (int i = 0; i < dly; i++) begin
      tick();
      check("R2", "devsel while waiting", int'(devsel_o), 1);
      check("R2", "trdy while waiting", int'(trdy_o), 0);
    end
    wd = 8'($urandom);
    wdata_i = wd; irdy_i = 1'b1; frame_i = burst;
    rty = predict_retry(wr, 2 + dly, s, st, h);
    tick();
    if (rty) begin
      check("R3", "retry stop", int'(stop_o), 1);
      check("R3", "retry trdy", int'(trdy_o), 0);
      check("R3", "retry lreq", int'(lreq_o), 0);
      check("R3", "retry devsel", int'(devsel_o), 1);
    end else begin
      check(wr ? "R5" : "R4", "lreq pulse", int'(lreq_o), 1);
      check(wr ? "R5" : "R4", "lwrite", int'(lwrite_o), int'(wr));
      if (wr) check("R5", "lwdata", int'(lwdata_o), int'(wd));
      lat = (s + st + h) < 1 ? 1 : (s + st + h);
      for (int i = 1; i < lat; i++) begin
        tick();
        check("R9", "single lreq", int'(lreq_o), 0);
        check(wr ? "R5" : "R4", "trdy before done", int'(trdy_o), 0);
      end
      rd = 8'($urandom);
      ldone_i = 1'b1; lrdata_i = rd;
      tick();
      ldone_i = 1'b0;
      check(wr ? "R5" : "R4", "trdy after done", int'(trdy_o), 1);
      check("R6", "stop on burst", int'(stop_o), int'(burst));
      check("R9", "lreq after done", int'(lreq_o), 0);
      if (!wr) check("R4", "rdata", int'(rdata_o), int'(rd));
    end
    irdy_i = 1'b0;
    if (burst && drain > 0) begin
      frame_i = 1'b1;
      for (int i = 0; i < drain; i++) begin
        tick();
        check("R7", "drain stop", int'(stop_o), 1);
        check("R7", "drain devsel", int'(devsel_o), 1);
        check("R7", "drain trdy", int'(trdy_o), 0);
      end
    end
    frame_i = 1'b0;
    tick();
    check_quiet("R7");
    prev_term = (gap == 0);
    for (int i = 0; i < gap; i++) tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_quiet("R1");
    rst_n = 1'b1;
    tick();
    check_quiet("R1");
    // Directed corner cases.
    run_txn(1'b0, 1'b1, 1'b0, 0, 4, 4, 4, 0, 1); // R4 prediction exactly 16
    run_txn(1'b0, 1'b1, 1'b0, 0, 4, 5, 4, 0, 1); // R3 prediction 17
    run_txn(1'b1, 1'b1, 1'b0, 5, 5, 5, 5, 0, 0); // R5 long write not retried
    run_txn(1'b0, 1'b1, 1'b1, 1, 1, 2, 1, 2, 0); // R6 R7 burst read
    run_txn(1'b1, 1'b1, 1'b1, 0, 0, 0, 0, 3, 0); // R6 R7 burst write
    run_txn(1'b0, 1'b1, 1'b1, 4, 3, 3, 3, 2, 0); // R3 R7 burst retry
    run_txn(1'b0, 1'b0, 1'b1, 1, 0, 0, 0, 0, 1); // R2 foreign
    run_txn(1'b0, 1'b1, 1'b0, 2, 1, 1, 1, 0, 0); // R8 back-to-back
    run_txn(1'b1, 1'b1, 1'b0, 0, 0, 1, 0, 0, 0); // R8
    for (int k = 0; k < 60; k++) begin
      run_txn(1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0),
              ($urandom_range(0, 2) == 0), $urandom_range(0, 4),
              $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
              $urandom_range(0, 3), $urandom_range(0, 2));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule